// File: doc/BRIEF.md
# PPS-Interpolated Event Timestamper

This block stamps asynchronous events of interest with GPS time. A free-running system clock of nominally 100 MHz drives a cycle counter that restarts on every rising edge of the one-pulse-per-second input. On each such edge the length of the interval that has just closed is latched in cycles, and a seconds counter advances. An event strobe captures the current second together with its cycle offset into that second, and both come from the same clock cycle.

The nanosecond field is not a fixed product of cycles and a nominal period. The offset is scaled by linear interpolation against the measured length of the previous PPS interval. A sequential restoring divider computes `offset * 10^9 / interval`, so a slow or fast oscillator is corrected in hardware. Captured events wait in a small queue ahead of the divider. Results leave as a valid/ready record, so a burst of thousands of events per second is absorbed without loss while the queue has room.

Until two PPS edges have been seen, no interval has been measured. In that case records carry a cleared reference flag and are scaled against the nominal 100,000,000 cycles per second.

Top module: `pps_event_stamper`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after release, `ts_valid_o` and `ovf_o` are 0.
- R2: `pps_i` passes through a two-stage synchronizer and only its rising edge acts. A PPS high first sampled at clock edge n takes effect at clock edge n+2, and a level held high for many cycles counts as one edge.
- R3: A 32-bit seconds counter starts at 0 after reset and increases by exactly 1 on each PPS edge. An event sampled at the same clock edge as a PPS edge belongs to the new second, with offset 0 and 0 ns.
- R4: On each PPS edge the interval just ended is latched. Its value is the number of clock cycles between that edge and the previous one.
- R5: An event sampled at clock edge m, after a PPS edge effective at n+2, has offset k = m-(n+2). Its record reports ns = floor(k * 1,000,000,000 / L), where L is the interval latched at that PPS edge.
- R6: Before the second PPS edge, records carry `ts_ref_ok_o` = 0 and use L = 100,000,000, so ns = 10*k. From the second edge onward, `ts_ref_ok_o` = 1.
- R7: When k >= L, the record reports ns = 999,999,999.
- R8: Up to 16 captured events are queued, and records leave in capture order.
- R9: An event that arrives while the queue holds 16 entries is dropped and sets `ovf_o`, which stays at 1 until reset.
- R10: While `ts_valid_o` is 1 and `ts_ready_i` is 0, the record holds `ts_valid_o`, `ts_sec_o`, `ts_ns_o` and `ts_ref_ok_o` unchanged.
- R11: Every record reports `ts_ns_o` below 1,000,000,000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, nominally 100 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pps_i | input | 1 | One-pulse-per-second input, asynchronous |
| event_i | input | 1 | Event strobe, one capture per high cycle, synchronous to `clk_i` |
| ts_valid_o | output | 1 | A timestamp record is available |
| ts_ready_i | input | 1 | Consumer accepts the record |
| ts_sec_o | output | 32 | Whole second of the event |
| ts_ns_o | output | 30 | Interpolated nanoseconds since the PPS edge |
| ts_ref_ok_o | output | 1 | 1 when a measured interval was used as the divisor |
| ovf_o | output | 1 | Sticky flag: an event was dropped on a full queue |

## Verification
On every cycle the checker covers these properties: the seconds counter steps by one only on a PPS edge, two edges never fall on adjacent cycles, the queue occupancy stays within its depth, and the overflow flag is sticky and rises only on an event that meets a full queue. It also covers record stability under backpressure and the sub-second range of the nanosecond field. The bench scenarios are the only source of evidence for the arithmetic: that the divisor is the interval actually measured and not a constant, the nominal scaling before a reference exists, saturation once the offset outgrows the previous interval, the edge-cycle event, and which events of an overlong burst survive.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int unsigned CNT_W = 28;
  localparam int unsigned SEC_W = 32;
  localparam int unsigned NS_W = 30;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;
  localparam int unsigned PROD_W = CNT_W + NS_W;

  typedef logic [CNT_W-1:0] cyc_t;

  typedef struct packed {
    logic             ref_ok;
    logic [SEC_W-1:0] sec;
    cyc_t             off;
    cyc_t             div;
  } stamp_req_t;
endpackage

// File: rtl/pes_time_base.sv
module pes_time_base
  import pes_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NOMINAL_CYC = 100_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  output logic             edge_o,
  output logic [SEC_W-1:0] sec_o,
  output stamp_req_t       cap_o
);
  localparam cyc_t CYC_MAX = '1;
  localparam cyc_t NOMINAL = cyc_t'(NOMINAL_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pps_prev_q;
  logic                   pps_edge;
  cyc_t                   cyc_q, len_q, cyc_inc;
  logic [SEC_W-1:0]       sec_q;
  logic [1:0]             seen_q, seen_nxt;
  logic                   ref_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      pps_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], pps_i};
      pps_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pps_edge = sync_q[SYNC_STAGES-1] & ~pps_prev_q;
  assign cyc_inc  = (cyc_q == CYC_MAX) ? CYC_MAX : cyc_q + 1'b1;
  assign seen_nxt = (pps_edge && seen_q != 2'd2) ? seen_q + 2'd1 : seen_q;
  assign ref_nxt  = (seen_nxt == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      len_q  <= '0;
      sec_q  <= '0;
      seen_q <= '0;
    end else begin
      seen_q <= seen_nxt;
      if (pps_edge) begin
        cyc_q <= '0;
        len_q <= cyc_inc;  // edge cycle included
        sec_q <= sec_q + 1'b1;
      end else begin
        cyc_q <= cyc_inc;
      end
    end
  end

  // capture reflects the state after this cycle's edge, if any
  always_comb begin
    cap_o.ref_ok = ref_nxt;
    cap_o.sec    = pps_edge ? sec_q + 1'b1 : sec_q;
    cap_o.off    = pps_edge ? '0 : cyc_inc;
    if (!ref_nxt)      cap_o.div = NOMINAL;
    else if (pps_edge) cap_o.div = cyc_inc;
    else               cap_o.div = len_q;
  end

  assign edge_o = pps_edge;
  assign sec_o  = sec_q;
endmodule

// File: rtl/pes_fifo.sv
module pes_fifo #(
  parameter type         T     = logic,
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  T                             data_i,
  output logic                         full_o,
  input  logic                         pop_i,
  output logic                         valid_o,
  output T                             data_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned OCC_W = $clog2(DEPTH+1);

  T                 mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [OCC_W-1:0] occ_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (occ_q == OCC_W'(DEPTH));
  assign valid_o = (occ_q != '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign data_o  = mem_q[rd_q];
  assign count_o = occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      occ_q <= occ_q + OCC_W'(do_push) - OCC_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/pes_interp_div.sv
module pes_interp_div
  import pes_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  stamp_req_t       req_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [SEC_W-1:0] res_sec_o,
  output logic [NS_W-1:0]  res_ns_o,
  output logic             res_ref_o
);
  localparam int unsigned     STEP_W = $clog2(PROD_W);
  localparam logic [NS_W-1:0] NS_SAT = NS_W'(NS_PER_SEC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_HOLD} st_e;

  st_e               st_q;
  cyc_t              div_q, rem_q, rem_nxt;
  logic [PROD_W-1:0] dq_q, dq_nxt;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W:0]    shifted;
  logic [CNT_W+1:0]  diff;
  logic [SEC_W-1:0]  sec_q;
  logic [NS_W-1:0]   ns_q;
  logic              ref_q;

  // one restoring step: dividend bits leave at the top, quotient bits enter at the bottom
  always_comb begin
    shifted = {rem_q, dq_q[PROD_W-1]};
    diff    = {1'b0, shifted} - {2'b00, div_q};
    if (diff[CNT_W+1]) begin
      rem_nxt = shifted[CNT_W-1:0];
      dq_nxt  = {dq_q[PROD_W-2:0], 1'b0};
    end else begin
      rem_nxt = diff[CNT_W-1:0];
      dq_nxt  = {dq_q[PROD_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      div_q  <= '0;
      rem_q  <= '0;
      dq_q   <= '0;
      step_q <= '0;
      sec_q  <= '0;
      ns_q   <= '0;
      ref_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          sec_q <= req_i.sec;
          ref_q <= req_i.ref_ok;
          if (req_i.off >= req_i.div) begin
            ns_q <= NS_SAT;
            st_q <= ST_HOLD;
          end else begin
            div_q  <= req_i.div;
            rem_q  <= '0;
            dq_q   <= PROD_W'(req_i.off) * PROD_W'(NS_PER_SEC);
            step_q <= STEP_W'(PROD_W - 1);
            st_q   <= ST_CALC;
          end
        end
        ST_CALC: begin
          rem_q <= rem_nxt;
          dq_q  <= dq_nxt;
          if (step_q == '0) begin
            ns_q <= dq_nxt[NS_W-1:0];
            st_q <= ST_HOLD;
          end else begin
            step_q <= step_q - 1'b1;
          end
        end
        ST_HOLD: if (res_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign res_valid_o = (st_q == ST_HOLD);
  assign res_sec_o   = sec_q;
  assign res_ns_o    = ns_q;
  assign res_ref_o   = ref_q;
endmodule

// File: rtl/pps_event_stamper.sv
module pps_event_stamper
  import pes_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NOMINAL_CYC = 100_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic             event_i,
  output logic             ts_valid_o,
  input  logic             ts_ready_i,
  output logic [SEC_W-1:0] ts_sec_o,
  output logic [NS_W-1:0]  ts_ns_o,
  output logic             ts_ref_ok_o,
  output logic             ovf_o
);
  localparam int unsigned FCNT_W = $clog2(FIFO_DEPTH+1);

  stamp_req_t        cap, head;
  logic              pps_edge, fifo_full, fifo_valid, div_ready;
  logic [SEC_W-1:0]  sec_cnt;
  logic [FCNT_W-1:0] fifo_cnt;
  logic              ovf_q;

  pes_time_base #(
    .SYNC_STAGES(SYNC_STAGES),
    .NOMINAL_CYC(NOMINAL_CYC)
  ) u_time_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pps_i (pps_i),
    .edge_o(pps_edge),
    .sec_o (sec_cnt),
    .cap_o (cap)
  );

  pes_fifo #(
    .T    (stamp_req_t),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (event_i),
    .data_i (cap),
    .full_o (fifo_full),
    .pop_i  (div_ready),
    .valid_o(fifo_valid),
    .data_o (head),
    .count_o(fifo_cnt)
  );

  pes_interp_div u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(fifo_valid),
    .req_ready_o(div_ready),
    .req_i      (head),
    .res_valid_o(ts_valid_o),
    .res_ready_i(ts_ready_i),
    .res_sec_o  (ts_sec_o),
    .res_ns_o   (ts_ns_o),
    .res_ref_o  (ts_ref_ok_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ovf_q <= 1'b0;
    else if (event_i && fifo_full) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/pes_checker.sv
module pes_checker #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned FCNT_W     = 5,
  parameter int unsigned SEC_W      = 32,
  parameter int unsigned NS_W       = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              event_i,
  input logic              pps_edge,
  input logic [SEC_W-1:0]  sec_cnt,
  input logic              fifo_full,
  input logic [FCNT_W-1:0] fifo_cnt,
  input logic              ovf_o,
  input logic              ts_valid_o,
  input logic              ts_ready_i,
  input logic [SEC_W-1:0]  ts_sec_o,
  input logic [NS_W-1:0]   ts_ns_o,
  input logic              ts_ref_ok_o
);
  assert_edge_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_edge |=> !pps_edge);

  assert_sec_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_edge |=> (sec_cnt == $past(sec_cnt) + 1'b1));

  assert_sec_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pps_edge |=> $stable(sec_cnt));

  assert_fifo_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= FCNT_W'(FIFO_DEPTH));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  assert_ovf_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(event_i && fifo_full));

  assert_record_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_valid_o && !ts_ready_i) |=> (ts_valid_o && $stable(ts_sec_o)
                                     && $stable(ts_ns_o) && $stable(ts_ref_ok_o)));

  assert_ns_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |-> (ts_ns_o < NS_W'(1_000_000_000)));
endmodule

bind pps_event_stamper pes_checker #(
  .FIFO_DEPTH(FIFO_DEPTH),
  .FCNT_W    (FCNT_W),
  .SEC_W     (pes_pkg::SEC_W),
  .NS_W      (pes_pkg::NS_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .event_i    (event_i),
  .pps_edge   (pps_edge),
  .sec_cnt    (sec_cnt),
  .fifo_full  (fifo_full),
  .fifo_cnt   (fifo_cnt),
  .ovf_o      (ovf_o),
  .ts_valid_o (ts_valid_o),
  .ts_ready_i (ts_ready_i),
  .ts_sec_o   (ts_sec_o),
  .ts_ns_o    (ts_ns_o),
  .ts_ref_ok_o(ts_ref_ok_o)
);

// File: tb/pps_event_stamper_tb.sv
`timescale 1ns/1ps
module pps_event_stamper_tb;
  logic        clk = 1'b0, rst_n = 1'b0, pps = 1'b0, evt = 1'b0, rdy = 1'b1;
  logic        vld, ovf, ref_ok;
  logic [31:0] sec;
  logic [29:0] ns;

  int checks = 0, fails = 0;
  int unsigned     q_sec[$]; longint unsigned q_ns[$]; bit q_ref[$]; string q_tag[$];
  int unsigned     g_sec[$]; longint unsigned g_ns[$]; bit g_ref[$];
  bit rec_mode = 0, bp_mode = 0;
  int bp_ctr = 0, pulses = 0, prev_len = 0;
  logic [31:0] h_sec; logic [29:0] h_ns; bit h_ref, h_pend = 0;

  always #5 clk = ~clk;

  pps_event_stamper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .event_i(evt),
    .ts_valid_o(vld), .ts_ready_i(rdy), .ts_sec_o(sec), .ts_ns_o(ns),
    .ts_ref_ok_o(ref_ok), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // consumer: ready chosen first, then the transfer at the next edge is recorded
  always @(negedge clk) begin
    if (rst_n) begin
      rdy = bp_mode ? (bp_ctr % 3 == 0) : 1'b1;
      bp_ctr++;
      if (h_pend)
        chk(vld && sec == h_sec && ns == h_ns && ref_ok == h_ref, "R10",
            "record changed under backpressure, ns", ns, h_ns);
      h_pend = 0;
      if (vld) begin
        if (!rdy) begin
          h_pend = 1; h_sec = sec; h_ns = ns; h_ref = ref_ok;
        end else begin
          chk(ns < 30'd1_000_000_000, "R11", "ns range", ns, 999_999_999);
          if (rec_mode) begin
            g_sec.push_back(sec); g_ns.push_back(ns); g_ref.push_back(ref_ok);
          end else if (q_sec.size() == 0) begin
            chk(0, "R8", "unexpected record, ns", ns, 0);
          end else begin
            chk(sec == q_sec[0] && ns == q_ns[0] && ref_ok == q_ref[0], q_tag[0],
                $sformatf("sec %0d/%0d ref %0d/%0d ns", sec, q_sec[0], ref_ok, q_ref[0]),
                ns, q_ns[0]);
            void'(q_sec.pop_front()); void'(q_ns.pop_front());
            void'(q_ref.pop_front()); void'(q_tag.pop_front());
          end
        end
      end
    end
  end

  task automatic expect_evt(input int k, input int div, input bit rf, input string tag);
    longint unsigned e;
    string t;
    t = tag;
    if (k >= div) begin e = 999_999_999; t = "R7"; end
    else e = (longint'(k) * 64'd1_000_000_000) / longint'(div);
    q_sec.push_back(pulses); q_ns.push_back(e); q_ref.push_back(rf); q_tag.push_back(t);
  endtask

  // one PPS interval of len cycles; events at offsets k0..k0+n0-1 and k1
  task automatic run_second(input int len, input int hold, input int k0, input int n0,
                            input int k1, input string tag);
    int div;
    bit rf;
    pulses++;
    rf  = (pulses >= 2);
    div = rf ? prev_len : 100_000_000;
    for (int c = 0; c < len; c++) begin
      pps = (c < hold);
      evt = ((c - 2) >= k0 && (c - 2) < k0 + n0) || (k1 >= 0 && (c - 2) == k1);
      if (evt) expect_evt(c - 2, div, rf, tag);
      @(negedge clk);
    end
    pps = 0; evt = 0;
    prev_len = len;
  endtask

  task automatic expect_drained(input string tag);
    chk(q_sec.size() == 0, tag, "records still pending", q_sec.size(), 0);
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    chk(vld == 1'b0, "R1", "valid in reset", vld, 0);
    chk(ovf == 1'b0, "R1", "ovf in reset", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0, "R1", "valid after reset", vld, 0);
    chk(ovf == 1'b0, "R1", "ovf after reset", ovf, 0);
  endtask

  task automatic test_unreferenced();   // R6: nominal divisor, 10 ns per cycle
    run_second(400, 1, 37, 1, 200, "R6");
    expect_drained("R6");
  endtask

  task automatic test_first_reference(); // R4 / R5: divisor is the 400-cycle interval
    run_second(500, 1, 123, 1, 399, "R4");
    expect_drained("R4");
  endtask

  task automatic test_interp();          // R5: divisor 500
    run_second(537, 1, 10, 1, 300, "R5");
    expect_drained("R5");
  endtask

  task automatic test_edge_cycle();      // R3: event on the edge cycle, then divisor 537
    run_second(463, 1, 0, 1, 300, "R3");
    expect_drained("R3");
  endtask

  task automatic test_held_pps();        // R2: long high level counts once
    run_second(600, 50, 250, 1, -1, "R2");
    run_second(700, 1, 20, 1, -1, "R2");
    expect_drained("R2");
  endtask

  task automatic test_saturation();      // R7: offsets at and past the 300-cycle interval
    run_second(300, 1, 100, 1, -1, "R5");
    run_second(900, 1, 299, 2, 700, "R7");
    expect_drained("R7");
  endtask

  task automatic test_burst_fit();       // R8: 16 back-to-back events fit
    run_second(1500, 1, 100, 16, -1, "R8");
    expect_drained("R8");
    chk(ovf == 1'b0, "R8", "ovf after 16-event burst", ovf, 0);
  endtask

  task automatic test_backpressure();    // R10
    bp_mode = 1;
    run_second(1000, 1, 50, 3, 600, "R10");
    bp_mode = 0;
    expect_drained("R10");
  endtask

  task automatic test_overflow();        // R9
    rec_mode = 1;
    run_second(2000, 1, 100, 30, -1, "R9");
    rec_mode = 0;
    chk(ovf == 1'b1, "R9", "ovf after 30-event burst", ovf, 1);
    chk(g_sec.size() >= 16 && g_sec.size() <= 18, "R9", "records kept", g_sec.size(), 17);
    for (int i = 0; i < g_sec.size() && i < q_sec.size(); i++)
      chk(g_sec[i] == q_sec[i] && g_ns[i] == q_ns[i] && g_ref[i] == q_ref[i], "R9",
          $sformatf("kept record %0d ns", i), g_ns[i], q_ns[i]);
    q_sec.delete(); q_ns.delete(); q_ref.delete(); q_tag.delete();
    g_sec.delete(); g_ns.delete(); g_ref.delete();
    run_second(300, 1, 50, 1, -1, "R9");
    expect_drained("R9");
    chk(ovf == 1'b1, "R9", "ovf sticky", ovf, 1);
  endtask

  initial begin
    test_reset();
    test_unreferenced();
    test_first_reference();
    test_interp();
    test_edge_cycle();
    test_held_pps();
    test_saturation();
    test_burst_fit();
    test_backpressure();
    test_overflow();
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule